// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A caller presents a virtual address, the table base value and a flag saying whether tiny pages are supported. The walker then issues one or two word reads on a request/valid memory port and decodes each returned descriptor. It finishes with a one-cycle done pulse carrying either a physical address with two cacheable/bufferable bits, or a fault.

The first-level descriptor chooses among three outcomes: a section that ends the walk at once, a coarse second-level table, or a fine second-level table. A second-level descriptor then selects a large, small or tiny page. Each page size keeps a different number of virtual address bits as the offset. Only one walk is in flight at a time. Requests that arrive while a walk is running are dropped.

The controller has four states. `ST_IDLE` waits for a request. `ST_FETCH_L1` holds the first-level read. `ST_FETCH_L2` holds the second-level read. `ST_REPORT` drives the done pulse. The transitions are:
- idle→fetch-L1 when a request is accepted.
- fetch-L1→report on an error response, a fault, or a section.
- fetch-L1→fetch-L2 on a coarse table, or on a fine table when tiny pages are enabled.
- fetch-L2→report on any response.
- report→idle unconditionally.

Top module: `page_walker`

## Requirements
- R1: The first-level read address is `{base[31:14], va[31:20], 2'b00}`.
- R2: First-level type bits [1:0] decode as follows: 0 is a fault, 1 is a coarse table, 2 is a section and 3 is a fine table. Type 0 ends the walk with a fault after one read.
- R3: When the tiny-page enable is low, a first-level type of 3 faults after one read and makes no second-level read.
- R4: A section gives `pa = {desc[31:20], va[19:0]}` and `cb = desc[3:2]`, and makes no second read.
- R5: For a coarse table, the second-level read address is `{l1[31:10], va[19:12], 2'b00}`.
- R6: For a fine table, the second-level read address is `{l1[31:12], va[19:10], 2'b00}`.
- R7: Second-level type bits [1:0] equal to 0 end the walk with a fault.
- R8: Second-level types map to physical addresses as follows: type 1 (large) gives `{desc[31:16], va[15:0]}`, type 2 (small) gives `{desc[31:12], va[11:0]}`, and type 3 (tiny) gives `{desc[31:10], va[9:0]}`.
- R9: For a valid second-level descriptor, `cb = desc[3:2]`.
- R10: `busy` is high during the fetch states. `done` is high for exactly one cycle per accepted request and never together with `busy`. Requests arriving while not idle are ignored.
- R11: On a fault, `pa` and `cb` are zero while `done` is high.
- R12: `mem_addr` stays stable and `mem_req` stays high until `mem_valid`. An error response on either read ends the walk with a fault on the next cycle.
- R13: Synchronous active-high reset returns to idle and clears `done`, `fault` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, accepted only when idle |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Translation table base value |
| tiny_en | input | 1 | Tiny pages (fine tables) supported |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation fault, valid with done |
| pa | output | 32 | Physical address, valid with done |
| cb | output | 2 | Cacheable/bufferable bits, valid with done |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_valid | input | 1 | Read data returned |
| mem_err | input | 1 | Read error, qualified by mem_valid |
| mem_rdata | input | 32 | Returned descriptor word |

## Verification
The bench builds the walker at its only width, 32-bit words. The descriptor decode depends on just a few type and attribute bits, so a sweep can cover all of them:
- every first-level type, with both settings of the tiny-page enable;
- every second-level type and every cacheable/bufferable value;
- three memory latencies;
- an error injected at either read, or at neither.

Each walk uses a hashed virtual address and table base, so the index and offset fields change from walk to walk. For each walk the bench checks both read addresses, the number of reads and the reported result. On every third walk it also sends a request during the walk to confirm that the request is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CB_W   = 2;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'd0,
        L2_LARGE = 2'd1,
        L2_SMALL = 2'd2,
        L2_TINY  = 2'd3
    } l2_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_L1,
        ST_FETCH_L2,
        ST_REPORT
    } walk_state_e;

    typedef struct packed {
        logic              fault;
        logic [CB_W-1:0]   cb;
        logic [WORD_W-1:0] pa;
    } walk_result_t;

    localparam walk_result_t FAULT_RESULT = '{fault: 1'b1, cb: '0, pa: '0};
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] l1_desc,
    input  logic              fine,
    output logic [WORD_W-1:0] l1_addr,
    output logic [WORD_W-1:0] l2_addr
);
    // first level: 4096 word entries indexed by the top 12 VA bits
    assign l1_addr = {base[31:14], va[31:20], 2'b00};

    // second level: coarse tables have 256 entries, fine tables 1024
    always_comb begin
        if (fine) begin
            l2_addr = {l1_desc[31:12], va[19:10], 2'b00};
        end else begin
            l2_addr = {l1_desc[31:10], va[19:12], 2'b00};
        end
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] desc,
    input  logic              tiny_en,
    output walk_result_t      res,
    output logic              descend,
    output logic              fine
);
    generate
        if (LEVEL == 1) begin : g_first
            l1_kind_e kind;
            assign kind = l1_kind_e'(desc[1:0]);
            always_comb begin
                res     = FAULT_RESULT;
                descend = 1'b0;
                fine    = 1'b0;
                unique case (kind)
                    L1_FAULT: res = FAULT_RESULT;
                    L1_SECTION: begin
                        res.fault = 1'b0;
                        res.cb    = desc[3:2];
                        res.pa    = {desc[31:20], va[19:0]};
                    end
                    L1_COARSE: descend = 1'b1;
                    L1_FINE: begin
                        descend = tiny_en;
                        fine    = tiny_en;
                    end
                endcase
            end
        end else begin : g_second
            l2_kind_e kind;
            assign kind    = l2_kind_e'(desc[1:0]);
            assign descend = 1'b0;
            assign fine    = tiny_en & 1'b0;
            always_comb begin
                res.fault = 1'b0;
                res.cb    = desc[3:2];
                res.pa    = '0;
                unique case (kind)
                    L2_FAULT: res = FAULT_RESULT;
                    L2_LARGE: res.pa = {desc[31:16], va[15:0]};
                    L2_SMALL: res.pa = {desc[31:12], va[11:0]};
                    L2_TINY:  res.pa = {desc[31:10], va[9:0]};
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic [31:0]       req_base,
    input  logic              tiny_en,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [31:0]       pa,
    output logic [1:0]        cb,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata
);
    walk_state_e       state, state_nx;
    logic [WORD_W-1:0] va_q, base_q, l1_q;
    logic              tiny_q, fine_q;
    walk_result_t      res_q;

    walk_result_t      l1_res, l2_res;
    logic              l1_descend, l1_fine, l2_descend_unused, l2_fine_unused;
    logic [WORD_W-1:0] l1_addr, l2_addr;

    ptw_addr_gen u_addr (
        .va      (va_q),
        .base    (base_q),
        .l1_desc (l1_q),
        .fine    (fine_q),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    ptw_desc_decode #(.LEVEL(1)) u_dec_l1 (
        .va      (va_q),
        .desc    (mem_rdata),
        .tiny_en (tiny_q),
        .res     (l1_res),
        .descend (l1_descend),
        .fine    (l1_fine)
    );

    ptw_desc_decode #(.LEVEL(2)) u_dec_l2 (
        .va      (va_q),
        .desc    (mem_rdata),
        .tiny_en (tiny_q),
        .res     (l2_res),
        .descend (l2_descend_unused),
        .fine    (l2_fine_unused)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_FETCH_L1;
            ST_FETCH_L1: if (mem_valid) begin
                if (!mem_err && l1_descend) state_nx = ST_FETCH_L2;
                else                        state_nx = ST_REPORT;
            end
            ST_FETCH_L2: if (mem_valid) state_nx = ST_REPORT;
            ST_REPORT:   state_nx = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            va_q   <= '0;
            base_q <= '0;
            l1_q   <= '0;
            tiny_q <= 1'b0;
            fine_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    base_q <= req_base;
                    tiny_q <= tiny_en;
                end
                ST_FETCH_L1: if (mem_valid) begin
                    if (mem_err) begin
                        res_q <= FAULT_RESULT;
                    end else if (l1_descend) begin
                        l1_q   <= mem_rdata;
                        fine_q <= l1_fine;
                    end else begin
                        res_q <= l1_res;
                    end
                end
                ST_FETCH_L2: if (mem_valid) begin
                    res_q <= mem_err ? FAULT_RESULT : l2_res;
                end
                ST_REPORT: ;
            endcase
        end
    end

    assign busy     = (state == ST_FETCH_L1) || (state == ST_FETCH_L2);
    assign done     = (state == ST_REPORT);
    assign mem_req  = busy;
    assign mem_addr = (state == ST_FETCH_L2) ? l2_addr : l1_addr;
    assign fault    = res_q.fault;
    assign pa       = res_q.pa;
    assign cb       = res_q.cb;

    p_addr_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_err_ends_walk_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid && mem_err) |=> (done && fault));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_fault_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (pa == '0 && cb == '0));

    p_reset_clears_r13: assert property (@(posedge clk)
        rst |=> (!done && !fault && !busy));
endmodule

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0, req_base = '0;
    logic        tiny_en = 1'b0;
    logic        busy, done, fault, mem_req;
    logic [31:0] pa, mem_addr;
    logic [1:0]  cb;
    logic        mem_valid = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    logic [31:0] m_l1, m_l2;
    int          m_err_at = 2, m_lat = 0, rd_cnt = 0, wait_cnt = 0;
    logic [31:0] rd_addr [2];

    always #2.5 clk = ~clk;

    page_walker i_page_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_base(req_base), .tiny_en(tiny_en), .busy(busy), .done(done),
        .fault(fault), .pa(pa), .cb(cb), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    // memory model: responds m_lat cycles after seeing a request
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_valid = 1'b0; mem_err = 1'b0; wait_cnt = 0;
            end else if (mem_valid) begin
                mem_valid = 1'b0; mem_err = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= m_lat) begin
                    if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
                    mem_rdata = (rd_cnt == 0) ? m_l1 : m_l2;
                    mem_err   = (m_err_at == rd_cnt);
                    rd_cnt++;
                    wait_cnt  = 0;
                    mem_valid = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic tiny, input logic [31:0] d1, input logic [31:0] d2,
                        input int err_at, input int lat, input bit poke);
        logic [31:0] e_l1a, e_l2a, e_pa;
        logic [1:0]  e_cb;
        logic        e_fault, got_done;
        int          e_reads;
        string       tag;
        e_l1a = {base[31:14], va[31:20], 2'b00};
        e_l2a = '0; e_pa = '0; e_cb = '0; e_fault = 1'b1; e_reads = 1; tag = "R2";
        if (err_at == 0) begin
            tag = "R12";
        end else if (d1[1:0] == 2'd0) begin
            tag = "R2";
        end else if (d1[1:0] == 2'd3 && !tiny) begin
            tag = "R3";
        end else if (d1[1:0] == 2'd2) begin
            tag = "R4"; e_fault = 1'b0; e_cb = d1[3:2]; e_pa = {d1[31:20], va[19:0]};
        end else begin
            e_reads = 2;
            e_l2a = (d1[1:0] == 2'd1) ? {d1[31:10], va[19:12], 2'b00}
                                      : {d1[31:12], va[19:10], 2'b00};
            if (err_at == 1) tag = "R12";
            else if (d2[1:0] == 2'd0) tag = "R7";
            else begin
                tag = "R8"; e_fault = 1'b0; e_cb = d2[3:2];
                case (d2[1:0])
                    2'd1:    e_pa = {d2[31:16], va[15:0]};
                    2'd2:    e_pa = {d2[31:12], va[11:0]};
                    default: e_pa = {d2[31:10], va[9:0]};
                endcase
            end
        end
        m_l1 = d1; m_l2 = d2; m_err_at = err_at; m_lat = lat; rd_cnt = 0;
        rd_addr[0] = 'x; rd_addr[1] = 'x;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_base = base; tiny_en = tiny;
        @(negedge clk);
        got_done = 1'b0;
        for (int k = 0; k < 100; k++) begin
            req_valid = (poke && k == 0);
            if (req_valid) begin req_va = ~va; req_base = ~base; tiny_en = ~tiny; end
            if (done) begin got_done = 1'b1; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R10", "done seen", {31'd0, got_done}, 32'd1);
        chk("R10", "busy with done", {31'd0, busy}, 32'd0);
        chk(tag, "fault", {31'd0, fault}, {31'd0, e_fault});
        chk(e_fault ? "R11" : tag, "pa", pa, e_pa);
        chk(e_fault ? "R11" : (e_reads == 2 ? "R9" : "R4"), "cb", {30'd0, cb}, {30'd0, e_cb});
        chk("R1", "l1 addr", rd_addr[0], e_l1a);
        chk(d1[1:0] == 2'd3 && !tiny ? "R3" : "R4", "read count", rd_cnt, e_reads);
        if (e_reads == 2)
            chk(d1[1:0] == 2'd1 ? "R5" : "R6", "l2 addr", rd_addr[1], e_l2a);
        @(negedge clk);
        chk("R10", "done one cycle", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R10", "no extra walk", {31'd0, busy}, 32'd0);
        chk("R10", "no extra read", rd_cnt, e_reads);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "done in reset", {31'd0, done}, 32'd0);
        chk("R13", "fault in reset", {31'd0, fault}, 32'd0);
        chk("R13", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R13", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;

        for (int t1 = 0; t1 < 4; t1++)
        for (int ti = 0; ti < 2; ti++)
        for (int t2 = 0; t2 < 4; t2++)
        for (int c = 0; c < 4; c++)
        for (int lat = 0; lat < 3; lat++)
        for (int e = 0; e < 3; e++) begin
            int unsigned idx;
            logic [31:0] h1, h2, va, base;
            idx  = ((((t1 * 2 + ti) * 4 + t2) * 4 + c) * 3 + lat) * 3 + e;
            va   = idx * 32'h9E3779B9 + 32'h1234567;
            base = idx * 32'h7F4A7C15 ^ 32'hA5A5C3C3;
            h1   = idx * 32'h85EBCA6B + 32'h27D4EB2F;
            h2   = idx * 32'hC2B2AE35 ^ 32'h165667B1;
            walk(va, base, ti[0],
                 (h1 & ~32'hF) | (c << 2) | t1,
                 (h2 & ~32'hF) | ((c ^ 1) << 2) | t2,
                 e, lat, (idx % 3) == 0);
        end

        // fault result then reset mid-walk clears outputs
        walk(32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 2, 0, 1'b0);
        m_lat = 20; rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h1; req_base = 32'h4000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "busy during walk", {31'd0, busy}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R13", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R13", "fault after reset", {31'd0, fault}, 32'd0);
        chk("R13", "done after reset", {31'd0, done}, 32'd0);
        chk("R13", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule